// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows a processor core through its power-management states and turns each state into clock, PLL and permission controls. It runs on a free-running reference clock. It reads these inputs: a halt request, the stop-clock request, the sleep request, a reset, a snoop-start strobe, a snoop-done strobe, and a flag that shows whether the bus clock is running. Each cycle it reports the current state code and several flags: whether the core clocks may run, whether the PLL stays powered, and whether snoops and interrupts can be accepted.

The state chain is strict. The sleep request only takes effect from Stop-Grant. Deep Sleep can only be reached from Sleep, by stopping the bus clock. When the bus clock comes back, the controller waits a full PLL relock interval before it reports Sleep again. A snoop taken in AutoHALT or Stop-Grant goes to a snoop-service state and returns to the state it came from.

Some stimulus is illegal while the core is dormant, and a sleep pulse can be too short. Either case sets a sticky protocol-violation flag, which only a reset clears. A reset taken from any state, Sleep included, goes straight to Normal.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `reset_n` is low at a clock edge, the next state is Normal, whatever the current state (Sleep included). In Normal, `core_clk_en`, `pll_en`, `snoop_ok` and `irq_latch_ok` are 1 and `proto_err` is 0.
- R2: `pstate` holds one of these codes: 1 Normal, 2 AutoHALT, 3 Stop-Grant, 4 Snoop-service, 5 Sleep, 6 Deep Sleep. No other value appears.
- R3: Normal goes to AutoHALT while `halt_req` is 1, and AutoHALT goes back to Normal when `halt_req` is 0. `stop_clk_n` = 0 in Normal or AutoHALT goes to Stop-Grant. `stop_clk_n` = 1 in Stop-Grant goes to AutoHALT if `halt_req` is 1, and to Normal otherwise.
- R4: `snoop_start` in AutoHALT or Stop-Grant goes to Snoop-service. The block stays there until `snoop_done`, then returns to the state it came from.
- R5: `sleep_n` = 0 has no effect in Normal or AutoHALT. In Stop-Grant it goes to Sleep on the next edge.
- R6: In Sleep, `core_clk_en` = 0 and `pll_en` = 1. In Sleep and Deep Sleep, `snoop_ok` and `irq_latch_ok` are 0.
- R7: `bus_clk_run` = 0 in Sleep goes to Deep Sleep on the next edge. In Deep Sleep, `pll_en` is 0 while `bus_clk_run` is 0.
- R8: Deep Sleep goes to Sleep only after `bus_clk_run` has been 1 for RELOCK_CYC consecutive edges (REF_KHZ*RELOCK_US/1000). If the bus clock stops during the wait, the count starts again.
- R9: `sleep_n` = 1 in Sleep goes to Stop-Grant on the next edge.
- R10: `proto_err` is set by any of these while in Sleep or Deep Sleep, or in the Stop-Grant cycle that takes `sleep_n` = 0: a `snoop_start` or `snoop_done` pulse, or any change of `halt_req` or `stop_clk_n`. Once set, it stays at 1 until reset.
- R11: The sleep-request pulse is counted in reference cycles, starting with the Stop-Grant cycle that samples `sleep_n` = 0 and ending with the last low cycle. If this count is less than MIN_SLP_CYC when Sleep is left, `proto_err` is set. A pulse of exactly MIN_SLP_CYC does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| reset_n | input | 1 | Synchronous reset request, active low |
| halt_req | input | 1 | Core halt request |
| stop_clk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| snoop_start | input | 1 | One-cycle strobe: a snoop has begun |
| snoop_done | input | 1 | One-cycle strobe: the snoop has been serviced |
| bus_clk_run | input | 1 | Bus clock is running |
| pstate | output | 3 | Current state code (R2) |
| core_clk_en | output | 1 | Internal core clocks may run |
| pll_en | output | 1 | PLL stays powered |
| snoop_ok | output | 1 | Snoop response allowed |
| irq_latch_ok | output | 1 | Interrupt latching allowed |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to reach is the relock boundary in Deep Sleep. It takes a legal Stop-Grant, then Sleep, then a bus-clock stop, then an interrupted restart, and finally an unbroken run. The bench builds this path one edge at a time. It confirms that the state is still Deep Sleep one edge before the relock count completes, and Sleep exactly on that edge. The sleep-pulse width is probed in the same way, at exactly MIN_SLP_CYC and at one cycle less, and the bench reads `proto_err` after each.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;

   typedef enum logic [2:0] {
      PS_NORMAL  = 3'd1,
      PS_AHALT   = 3'd2,
      PS_STOPGNT = 3'd3,
      PS_SNOOP   = 3'd4,
      PS_SLEEP   = 3'd5,
      PS_DEEP    = 3'd6
   } pstate_e;

   function automatic logic is_dormant(input pstate_e s);
      return (s == PS_SLEEP) || (s == PS_DEEP);
   endfunction

endpackage

// File: rtl/pwr_relock_timer.sv
`timescale 1ns/1ps
module pwr_relock_timer #(
   parameter int unsigned CYC = 50000
) (
   input  logic clk,
   input  logic reset_n,
   input  logic arm,
   output logic done
);
   localparam int unsigned CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt;

   assign done = arm && (cnt == CW'(CYC - 1));

   always_ff @(posedge clk) begin
      if (!reset_n || !arm) cnt <= '0;
      else if (!done)       cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pwr_slp_width.sv
`timescale 1ns/1ps
module pwr_slp_width #(
   parameter int unsigned MIN_CYC = 3
) (
   input  logic clk,
   input  logic reset_n,
   input  logic start,
   input  logic hold,
   output logic short_o
);
   generate
      if (MIN_CYC <= 1) begin : g_no_count
         assign short_o = 1'b0;
      end else begin : g_count
         localparam int unsigned CW = $clog2(MIN_CYC + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!reset_n)                          cnt <= '0;
            else if (start)                        cnt <= CW'(1);
            else if (hold && cnt != CW'(MIN_CYC))  cnt <= cnt + 1'b1;
         end
         assign short_o = (cnt < CW'(MIN_CYC));
      end
   endgenerate
endmodule

// File: rtl/pwr_rule_mon.sv
`timescale 1ns/1ps
module pwr_rule_mon (
   input  logic clk,
   input  logic reset_n,
   input  logic guarded,
   input  logic halt_req,
   input  logic stop_clk_n,
   input  logic snoop_start,
   input  logic snoop_done,
   input  logic short_exit,
   output logic err_o
);
   logic halt_q;
   logic stop_q;
   logic bad_input;

   always_ff @(posedge clk) begin
      halt_q <= halt_req;
      stop_q <= stop_clk_n;
   end

   assign bad_input = guarded &&
                      (snoop_start || snoop_done ||
                       (halt_req != halt_q) || (stop_clk_n != stop_q));

   always_ff @(posedge clk) begin
      if (!reset_n) err_o <= 1'b0;
      else          err_o <= err_o | bad_input | short_exit;
   end
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
module pwr_state_ctrl #(
   parameter int unsigned REF_KHZ     = 50000,
   parameter int unsigned RELOCK_US   = 1000,
   parameter int unsigned MIN_SLP_CYC = 3
) (
   input  logic       clk,
   input  logic       reset_n,
   input  logic       halt_req,
   input  logic       stop_clk_n,
   input  logic       sleep_n,
   input  logic       snoop_start,
   input  logic       snoop_done,
   input  logic       bus_clk_run,
   output logic [2:0] pstate,
   output logic       core_clk_en,
   output logic       pll_en,
   output logic       snoop_ok,
   output logic       irq_latch_ok,
   output logic       proto_err
);
   import pwr_state_pkg::*;

   localparam int unsigned RELOCK_CYC = (REF_KHZ * RELOCK_US) / 1000;

   if (REF_KHZ == 0) begin : g_bad_ref
      $error("REF_KHZ must be non-zero");
   end
   if (RELOCK_CYC < 2) begin : g_bad_relock
      $error("relock interval must span at least two reference cycles");
   end
   if (MIN_SLP_CYC == 0) begin : g_bad_min
      $error("MIN_SLP_CYC must be at least one");
   end

   pstate_e state, state_nx;
   logic    snoop_from_sg;
   logic    dormant;
   logic    entering;
   logic    relock_done;
   logic    pulse_short;
   logic    short_exit;

   assign dormant    = is_dormant(state);
   assign entering   = (state == PS_STOPGNT) && !sleep_n;
   assign short_exit = (state == PS_SLEEP) && sleep_n && pulse_short;

   pwr_relock_timer #(.CYC(RELOCK_CYC)) u_relock (
      .clk     (clk),
      .reset_n (reset_n),
      .arm     ((state == PS_DEEP) && bus_clk_run),
      .done    (relock_done)
   );

   pwr_slp_width #(.MIN_CYC(MIN_SLP_CYC)) u_width (
      .clk     (clk),
      .reset_n (reset_n),
      .start   (entering),
      .hold    (dormant && !sleep_n),
      .short_o (pulse_short)
   );

   pwr_rule_mon u_rules (
      .clk         (clk),
      .reset_n     (reset_n),
      .guarded     (dormant || entering),
      .halt_req    (halt_req),
      .stop_clk_n  (stop_clk_n),
      .snoop_start (snoop_start),
      .snoop_done  (snoop_done),
      .short_exit  (short_exit),
      .err_o       (proto_err)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         PS_NORMAL: begin
            if (!stop_clk_n)    state_nx = PS_STOPGNT;
            else if (halt_req)  state_nx = PS_AHALT;
         end
         PS_AHALT: begin
            if (!stop_clk_n)       state_nx = PS_STOPGNT;
            else if (snoop_start)  state_nx = PS_SNOOP;
            else if (!halt_req)    state_nx = PS_NORMAL;
         end
         PS_STOPGNT: begin
            if (!sleep_n)          state_nx = PS_SLEEP;
            else if (snoop_start)  state_nx = PS_SNOOP;
            else if (stop_clk_n)   state_nx = halt_req ? PS_AHALT : PS_NORMAL;
         end
         PS_SNOOP: begin
            if (snoop_done) state_nx = snoop_from_sg ? PS_STOPGNT : PS_AHALT;
         end
         PS_SLEEP: begin
            if (sleep_n)           state_nx = PS_STOPGNT;
            else if (!bus_clk_run) state_nx = PS_DEEP;
         end
         PS_DEEP: begin
            if (relock_done) state_nx = PS_SLEEP;
         end
         default: state_nx = PS_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!reset_n) begin
         state         <= PS_NORMAL;
         snoop_from_sg <= 1'b0;
      end else begin
         state <= state_nx;
         if (state_nx == PS_SNOOP && state != PS_SNOOP)
            snoop_from_sg <= (state == PS_STOPGNT);
      end
   end

   assign pstate       = state;
   assign core_clk_en  = !dormant;
   assign pll_en       = !((state == PS_DEEP) && !bus_clk_run);
   assign snoop_ok     = !dormant;
   assign irq_latch_ok = !dormant;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_state_ctrl_chk (
   input logic       clk,
   input logic       reset_n,
   input logic [2:0] pstate,
   input logic       snoop_done,
   input logic       bus_clk_run,
   input logic       proto_err
);
   // R2
   state_legal_chk: assert property (@(posedge clk) disable iff (!reset_n)
      (pstate >= 3'd1) && (pstate <= 3'd6));

   // R5
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!reset_n)
      (pstate == 3'd5 && $past(pstate) != 3'd5) |->
      ($past(pstate) == 3'd3 || $past(pstate) == 3'd6));

   // R7
   deep_entry_chk: assert property (@(posedge clk) disable iff (!reset_n)
      (pstate == 3'd6 && $past(pstate) != 3'd6) |-> ($past(pstate) == 3'd5));

   // R4
   snoop_return_chk: assert property (@(posedge clk) disable iff (!reset_n)
      (pstate == 3'd4 && snoop_done) |=> (pstate == 3'd2 || pstate == 3'd3));

   // R8
   relock_hold_chk: assert property (@(posedge clk) disable iff (!reset_n)
      (pstate == 3'd6 && !bus_clk_run) |=> (pstate == 3'd6));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!reset_n)
      proto_err |=> proto_err);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
   .clk         (clk),
   .reset_n     (reset_n),
   .pstate      (pstate),
   .snoop_done  (snoop_done),
   .bus_clk_run (bus_clk_run),
   .proto_err   (proto_err)
);

// File: tb/pwr_state_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_state_ctrl_bench;
   localparam int unsigned MIN_SLP = 3;
   localparam int unsigned RELOCK  = 50;

   logic       clk = 1'b0;
   logic       reset_n = 1'b0;
   logic       halt_req = 1'b0;
   logic       stop_clk_n = 1'b1;
   logic       sleep_n = 1'b1;
   logic       snoop_start = 1'b0;
   logic       snoop_done = 1'b0;
   logic       bus_clk_run = 1'b1;
   logic [2:0] pstate;
   logic       core_clk_en, pll_en, snoop_ok, irq_latch_ok, proto_err;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pwr_state_ctrl #(
      .REF_KHZ(50000), .RELOCK_US(1), .MIN_SLP_CYC(MIN_SLP)
   ) u_pwr_state_ctrl (
      .clk(clk), .reset_n(reset_n), .halt_req(halt_req),
      .stop_clk_n(stop_clk_n), .sleep_n(sleep_n),
      .snoop_start(snoop_start), .snoop_done(snoop_done),
      .bus_clk_run(bus_clk_run), .pstate(pstate),
      .core_clk_en(core_clk_en), .pll_en(pll_en), .snoop_ok(snoop_ok),
      .irq_latch_ok(irq_latch_ok), .proto_err(proto_err)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      halt_req = 1'b0; stop_clk_n = 1'b1; sleep_n = 1'b1;
      snoop_start = 1'b0; snoop_done = 1'b0; bus_clk_run = 1'b1;
      reset_n = 1'b0;
      step(2);
      reset_n = 1'b1;
   endtask

   task automatic go_sleep();
      stop_clk_n = 1'b0; step(1);
      sleep_n = 1'b0;    step(1);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 state", pstate, 1);
      chk("R1 core_clk_en", core_clk_en, 1);
      chk("R1 pll_en", pll_en, 1);
      chk("R1 snoop_ok", snoop_ok, 1);
      chk("R1 irq_latch_ok", irq_latch_ok, 1);
      chk("R1 proto_err", proto_err, 0);
   endtask

   task automatic t_halt_stop();
      do_reset();
      halt_req = 1'b1; step(1);   chk("R3 normal->ahalt", pstate, 2);
      sleep_n = 1'b0;  step(2);   chk("R5 sleep ignored in ahalt", pstate, 2);
      sleep_n = 1'b1;
      stop_clk_n = 1'b0; step(1); chk("R3 ahalt->stopgnt", pstate, 3);
      stop_clk_n = 1'b1; step(1); chk("R3 stopgnt->ahalt", pstate, 2);
      halt_req = 1'b0; step(1);   chk("R3 ahalt->normal", pstate, 1);
      sleep_n = 1'b0;  step(2);   chk("R5 sleep ignored in normal", pstate, 1);
      sleep_n = 1'b1;
      stop_clk_n = 1'b0; step(1); chk("R3 normal->stopgnt", pstate, 3);
      stop_clk_n = 1'b1; step(1); chk("R3 stopgnt->normal", pstate, 1);
   endtask

   task automatic t_snoop();
      do_reset();
      halt_req = 1'b1; step(1);
      snoop_start = 1'b1; step(1); snoop_start = 1'b0;
      chk("R4 ahalt->snoop", pstate, 4);
      step(3);                     chk("R4 snoop holds", pstate, 4);
      snoop_done = 1'b1; step(1); snoop_done = 1'b0;
      chk("R4 return ahalt", pstate, 2);
      stop_clk_n = 1'b0; step(1);
      snoop_start = 1'b1; step(1); snoop_start = 1'b0;
      chk("R4 stopgnt->snoop", pstate, 4);
      snoop_done = 1'b1; step(1); snoop_done = 1'b0;
      chk("R4 return stopgnt", pstate, 3);
      chk("R4 no error", proto_err, 0);
   endtask

   task automatic t_sleep();
      do_reset();
      go_sleep();
      chk("R5 stopgnt->sleep", pstate, 5);
      chk("R6 core_clk_en", core_clk_en, 0);
      chk("R6 pll_en", pll_en, 1);
      chk("R6 snoop_ok", snoop_ok, 0);
      chk("R6 irq_latch_ok", irq_latch_ok, 0);
      step(3);
      sleep_n = 1'b1; step(1);
      chk("R9 sleep->stopgnt", pstate, 3);
      chk("R9 no error", proto_err, 0);
   endtask

   task automatic t_deep();
      do_reset();
      go_sleep();
      bus_clk_run = 1'b0; step(1);
      chk("R7 sleep->deep", pstate, 6);
      chk("R7 pll off", pll_en, 0);
      chk("R6 deep snoop_ok", snoop_ok, 0);
      step(5);
      bus_clk_run = 1'b1; step(10);
      chk("R8 partial relock", pstate, 6);
      chk("R7 pll on while relocking", pll_en, 1);
      bus_clk_run = 1'b0; step(1);
      bus_clk_run = 1'b1; step(RELOCK - 1);
      chk("R8 one edge short", pstate, 6);
      step(1);
      chk("R8 relock complete", pstate, 5);
      sleep_n = 1'b1; step(1);
      chk("R9 exit to stopgnt", pstate, 3);
      chk("R8 no error", proto_err, 0);
   endtask

   task automatic t_violations();
      do_reset();
      go_sleep();
      snoop_start = 1'b1; step(1); snoop_start = 1'b0;
      chk("R10 snoop in sleep flags", proto_err, 1);
      chk("R10 state kept", pstate, 5);
      step(3);
      chk("R10 sticky", proto_err, 1);
      reset_n = 1'b0; step(1);
      chk("R1 reset from sleep", pstate, 1);
      chk("R1 reset clears error", proto_err, 0);
      sleep_n = 1'b1; stop_clk_n = 1'b1; reset_n = 1'b1;
      step(1);
      go_sleep();
      halt_req = 1'b1; step(1);
      chk("R10 halt change in sleep", proto_err, 1);
      do_reset();
      stop_clk_n = 1'b0; step(1);
      sleep_n = 1'b0; snoop_start = 1'b1; step(1); snoop_start = 1'b0;
      chk("R10 snoop on sleep entry", proto_err, 1);
      chk("R10 entry still sleeps", pstate, 5);
   endtask

   task automatic t_pulse_width();
      do_reset();
      stop_clk_n = 1'b0; step(1);
      sleep_n = 1'b0; step(MIN_SLP);
      sleep_n = 1'b1; step(1);
      chk("R11 exact width state", pstate, 3);
      chk("R11 exact width ok", proto_err, 0);
      sleep_n = 1'b0; step(MIN_SLP - 1);
      sleep_n = 1'b1; step(1);
      chk("R11 short width state", pstate, 3);
      chk("R11 short width flags", proto_err, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (completion)");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_halt_stop();
      t_snoop();
      t_sleep();
      t_deep();
      t_violations();
      t_pulse_width();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule